// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block collects interrupt events from the peripherals of a small microcontroller into one 8-bit flag register. The sources are an A/D conversion-done pulse, the UART receive-buffer-loaded and transmit-buffer-drained events, three comparator outputs, and a timer rollover pulse. The converter, UART, comparators and timer are not part of the block; only their signals enter it. A second 8-bit register holds per-source enables. The interrupt request output is active when any flag has its enable bit set and the global enable input is high.

The flags do not all clear the same way. The A/D, timer and comparator flags are sticky: software clears them by writing 0, and writing 1 sets them, which lets software force an interrupt for test. The two UART flags follow the state of the UART buffers. Software cannot write them. The receive flag clears when the receive data register is read, and the transmit flag clears when the transmit data register is written. A comparator flag records that the comparator output differs from a snapshot. The block takes that snapshot each time the flag register is read.

The register port is a simple strobe interface. `reg_addr` selects the flag register (0) or the enable register (1). A write takes effect at the clock edge. Read data is combinational. A read strobe is needed only to refresh the comparator snapshot.

Top module: `pir_flags`

## Requirements
- R1: After reset, the flag register reads 0x00, the enable register reads 0x00, `irq` is 0, and the comparator snapshot is 000.
- R2: Bit 7 of both registers always reads 0, and writes to it have no effect.
- R3: Flag bit 6 sets on an `adc_done` pulse and stays set until a register write puts 0 in bit 6.
- R4: Flag bit 5 sets on `rx_loaded` and clears on `rx_data_rd`. Register writes to bit 5 have no effect.
- R5: Flag bit 4 sets on `tx_emptied` and clears on `tx_data_wr`. Register writes to bit 4 have no effect.
- R6: Flag bit k+1 (k = 0..2) sets in every cycle where `cmp_out[k]` differs from the snapshot. The snapshot takes the value of `cmp_out` at each clock edge where `reg_rd` is high with `reg_addr` = 0.
- R7: Flag bit 0 sets on a `tmr_ovf` pulse and clears only through a register write of 0 to bit 0.
- R8: Every flag sets on its event whatever the values of the enable register and `gie`.
- R9: When a hardware set event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R10: A register write of 1 to any of flag bits 6, 3, 2, 1 or 0 sets that flag.
- R11: `irq` is 1 exactly when `gie` is 1 and some bit is 1 in both the flag register and the enable register. The enable register keeps bits 6..0 of the written value.
- R12: A flag set at a clock edge appears on `reg_rdata` and affects `irq` straight after that edge, with no further cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 flags, 1 enables |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (refreshes the comparator snapshot when reg_addr is 0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| adc_done | input | 1 | Conversion-complete pulse |
| rx_loaded | input | 1 | Receive buffer became full |
| rx_data_rd | input | 1 | Receive data register was read |
| tx_emptied | input | 1 | Transmit buffer became empty |
| tx_data_wr | input | 1 | Transmit data register was written |
| cmp_out | input | 3 | Comparator outputs, index k maps to flag bit k+1 |
| tmr_ovf | input | 1 | Timer rollover pulse |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Two things can happen to one flag in the same cycle: a hardware set and a software clear write. The bench pulses `adc_done` in the same cycle as a write of 0x00 to the flag register and expects bit 6 to stay set. The comparator flags give a second case. While a comparator output still differs from the snapshot, each write of 0 loses to the set, and the flag clears only after a flag-register read has refreshed the snapshot. The bench checks both the write that fails to clear and the write that succeeds.

// File: rtl/pir_flags.sv
module pir_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       adc_done,
  input  logic       rx_loaded,
  input  logic       rx_data_rd,
  input  logic       tx_emptied,
  input  logic       tx_data_wr,
  input  logic [2:0] cmp_out,
  input  logic       tmr_ovf,
  input  logic       gie,
  output logic       irq
);
  localparam logic [7:0] SW_MASK = 8'b0100_1111;
  localparam logic [7:0] EN_MASK = 8'b0111_1111;

  logic [7:0] flag_q, en_q, hw_set, hw_clr, sw_val;
  logic [2:0] cmp_snap;
  logic       wr_flag, wr_en, rd_flag;

  assign wr_flag = reg_wr && !reg_addr;
  assign wr_en   = reg_wr &&  reg_addr;
  assign rd_flag = reg_rd && !reg_addr;

  assign hw_set = {1'b0, adc_done, rx_loaded, tx_emptied, cmp_out ^ cmp_snap, tmr_ovf};
  assign hw_clr = {2'b00, rx_data_rd, tx_data_wr, 4'b0000};
  assign sw_val = wr_flag ? ((reg_wdata & SW_MASK) | (flag_q & ~SW_MASK)) : flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      en_q     <= '0;
      cmp_snap <= '0;
    end else begin
      flag_q <= hw_set | (sw_val & ~hw_clr);
      if (wr_en)   en_q     <= reg_wdata & EN_MASK;
      if (rd_flag) cmp_snap <= cmp_out;
    end
  end

  assign reg_rdata = reg_addr ? en_q : flag_q;
  assign irq       = gie && |(flag_q & en_q);
endmodule

// File: rtl/pir_flags_chk.sv
module pir_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] flag_q,
  input logic [7:0] en_q,
  input logic       adc_done,
  input logic       rx_loaded,
  input logic       rx_data_rd,
  input logic       tx_emptied,
  input logic       tx_data_wr,
  input logic       tmr_ovf,
  input logic       gie,
  input logic       irq
);
  assert_bit7_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (flag_q[7] == 1'b0 && en_q[7] == 1'b0));
  assert_adc_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_done |=> flag_q[6]);
  assert_adc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[6] && !(reg_wr && !reg_addr && !reg_wdata[6])) |=> flag_q[6]);
  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[5] && !rx_data_rd) |=> flag_q[5]);
  assert_rx_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data_rd && !rx_loaded) |=> !flag_q[5]);
  assert_tx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_data_wr && !tx_emptied) |=> !flag_q[4]);
  assert_tmr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> flag_q[0]);
  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && en_q != 8'h00 && flag_q != 8'h00));
endmodule

bind pir_flags pir_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .flag_q(flag_q), .en_q(en_q),
  .adc_done(adc_done), .rx_loaded(rx_loaded), .rx_data_rd(rx_data_rd),
  .tx_emptied(tx_emptied), .tx_data_wr(tx_data_wr), .tmr_ovf(tmr_ovf),
  .gie(gie), .irq(irq)
);

// File: tb/tb_pir_flags.sv
module tb_pir_flags;
  logic clk = 0, rst_n = 0;
  logic reg_addr = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic adc_done = 0, rx_loaded = 0, rx_data_rd = 0, tx_emptied = 0, tx_data_wr = 0;
  logic [2:0] cmp_out = 0;
  logic tmr_ovf = 0, gie = 0, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pir_flags dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input logic a, output logic [7:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wr = 1; reg_wdata = d;
    @(posedge clk); #1; reg_wr = 0;
  endtask

  task automatic rd_flags();
    @(negedge clk); reg_addr = 0; reg_rd = 1;
    @(posedge clk); #1; reg_rd = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(0, v); chk("R1 flags", v, 8'h00);
    peek(1, v); chk("R1 enables", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_write_masks();
    logic [7:0] v;
    wr(0, 8'hFF); peek(0, v); chk("R10/R2/R4/R5 write FF", v, 8'h4F);
    wr(0, 8'h00); peek(0, v); chk("R10 clear", v, 8'h00);
    wr(1, 8'hFF); peek(1, v); chk("R2 enable bit7", v, 8'h7F);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    gie = 1;
    wr(0, 8'h01); chk("R11 irq set", {7'b0, irq}, 8'h01);
    gie = 0; #0.5; chk("R11 gie off", {7'b0, irq}, 8'h00);
    gie = 1; wr(1, 8'h7E); chk("R11 masked", {7'b0, irq}, 8'h00);
    wr(0, 8'h00); wr(1, 8'h00); peek(0, v); chk("R11 cleanup", v, 8'h00);
  endtask

  task automatic t_adc();
    logic [7:0] v;
    gie = 0;
    @(negedge clk); adc_done = 1; @(posedge clk); #1; adc_done = 0;
    peek(0, v); chk("R3/R8/R12 adc set", v, 8'h40);
    wr(0, 8'h0F); peek(0, v); chk("R3 write 0 clears", v, 8'h0F);
    wr(0, 8'h00); peek(0, v); chk("R3 cleared", v, 8'h00);
    wr(1, 8'h40); gie = 1;
    @(negedge clk); adc_done = 1; @(posedge clk); #1; adc_done = 0;
    chk("R12 irq same cycle", {7'b0, irq}, 8'h01);
    wr(0, 8'h00); wr(1, 8'h00); gie = 0;
  endtask

  task automatic t_timer();
    logic [7:0] v;
    @(negedge clk); tmr_ovf = 1; @(posedge clk); #1; tmr_ovf = 0;
    repeat (3) @(posedge clk); #1;
    peek(0, v); chk("R7 timer sticky", v, 8'h01);
    rd_flags(); peek(0, v); chk("R7 read keeps", v, 8'h01);
    wr(0, 8'h00); peek(0, v); chk("R7 write clears", v, 8'h00);
  endtask

  task automatic t_rx_tx();
    logic [7:0] v;
    @(negedge clk); rx_loaded = 1; @(posedge clk); #1; rx_loaded = 0;
    peek(0, v); chk("R4 rx set", v, 8'h20);
    wr(0, 8'h00); peek(0, v); chk("R4 write ignored", v, 8'h20);
    @(negedge clk); rx_data_rd = 1; @(posedge clk); #1; rx_data_rd = 0;
    peek(0, v); chk("R4 rx clear", v, 8'h00);
    @(negedge clk); tx_emptied = 1; @(posedge clk); #1; tx_emptied = 0;
    peek(0, v); chk("R5 tx set", v, 8'h10);
    wr(0, 8'h00); peek(0, v); chk("R5 write ignored", v, 8'h10);
    @(negedge clk); tx_data_wr = 1; @(posedge clk); #1; tx_data_wr = 0;
    peek(0, v); chk("R5 tx clear", v, 8'h00);
  endtask

  task automatic t_cmp();
    logic [7:0] v;
    @(negedge clk); cmp_out = 3'b001; @(posedge clk); #1;
    peek(0, v); chk("R6 cmp0 change", v, 8'h02);
    wr(0, 8'h00); peek(0, v); chk("R6/R9 clear loses before read", v, 8'h02);
    rd_flags(); wr(0, 8'h00); peek(0, v); chk("R6 clear after read", v, 8'h00);
    @(negedge clk); cmp_out = 3'b101; @(posedge clk); #1;
    peek(0, v); chk("R6 cmp2 change", v, 8'h08);
    rd_flags(); wr(0, 8'h00);
    @(negedge clk); cmp_out = 3'b000; @(posedge clk); #1;
    peek(0, v); chk("R6 two comparators", v, 8'h0A);
    rd_flags(); wr(0, 8'h00); peek(0, v); chk("R6 final clear", v, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    @(negedge clk); reg_addr = 0; reg_wr = 1; reg_wdata = 8'h00; adc_done = 1;
    @(posedge clk); #1; reg_wr = 0; adc_done = 0;
    peek(0, v); chk("R9 set beats clear", v, 8'h40);
    wr(0, 8'h00); peek(0, v); chk("R9 later clear", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_write_masks();
    t_irq();
    t_adc();
    t_timer();
    t_rx_tx();
    t_cmp();
    t_set_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule